// File: doc/BRIEF.md
# Configuration Image Loader with Per-Block CRC

The loader takes in a configuration image one 16-bit word at a time and writes its payload into a coefficient memory. Words arrive either on a parallel write port, one word per clock while a write strobe is high, or on a framed serial input that is sampled on a chosen edge of an external serial clock. A serial frame-sync pulse marks the most significant bit of each word.

The image has a fixed layout. An identifier word comes first. Then come `NUM_BLOCKS` blocks, and each block is `BLOCK_WORDS` payload words followed by one check word. With the default parameters that is 12 blocks of 42 words, which gives 517 words and 504 stored words. Only payload words go to memory. The identifier and the check words are compared and then dropped.

A fully correct image raises a done flag. Any mismatch drives an active-low error flag, which stays low until a reset-config pulse. That pulse also restarts loading at the identifier. Once loading is done in serial mode, each further serial bit is forwarded unchanged on a pass-through output, so that a device further down a chain can load its own image.

Top module: `cfg_image_loader`

## Requirements
- R1: After `rstN` is released, `cfgDone`=0, `cfgErrN`=1, `memWrEn`=0 and `passData`=0.
- R2: The first accepted word must equal `ID_WORD` (default 0x7725). Any other value drives `cfgErrN` low from the next clock, and nothing is written to memory.
- R3: After the identifier, the loader writes the payload words to consecutive addresses starting at 0. `memWrEn`, `memAddr` and `memWrData` appear one clock after the word is accepted. The identifier and the check words are never written.
- R4: Each check word must equal a CRC-16 over that block's payload words. The CRC uses polynomial 0x1021 and seed 0xFFFF, is computed MSB first, and is re-seeded for every block. A mismatch drives `cfgErrN` low from the next clock, and no later payload is written.
- R5: `cfgDone` rises one clock after the last check word is accepted, provided every check passed. It then stays high, and further words write nothing. `cfgDone` and a low `cfgErrN` are never present together.
- R6: A low `cfgErrN` ignores all further words and stays low until a one-clock `cfgResetPulse`. That pulse sets `cfgErrN`=1 and `cfgDone`=0, and the loader then expects the identifier again.
- R7: In serial mode, a bit sampled while `frameSync` is high is the MSB of a new word. The next 15 sampled bits complete that word, MSB first. Bits sampled outside a frame are ignored.
- R8: `edgeSel`=0 samples `serDataIn` and `frameSync` on a rising edge of `serClk`. `edgeSel`=1 samples them on a falling edge.
- R9: With `serialMode`=0, the loader accepts `parData` on every clock where `parWrEn`=1, and the serial pins have no effect. With `serialMode`=1, `parWrEn` has no effect.
- R10: While `standby` is high, words are ignored. If standby arrives during a partly loaded image, loading restarts at the identifier. If standby arrives when loading is done, `cfgDone` stays high.
- R11: With `cfgDone`=1 and `serialMode`=1, `passData` takes each sampled serial bit at the clock that samples it. Otherwise `passData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgResetPulse | input | 1 | Clears the error and done flags and restarts loading |
| standby | input | 1 | Low-power request; aborts a partial load |
| serialMode | input | 1 | 1 = serial source, 0 = parallel source |
| edgeSel | input | 1 | Serial sampling edge: 0 = rising, 1 = falling |
| serClk | input | 1 | Serial bit clock, sampled by `clk` |
| frameSync | input | 1 | Marks the MSB of a serial word |
| serDataIn | input | 1 | Serial data, MSB first |
| parWrEn | input | 1 | Parallel word strobe |
| parData | input | 16 | Parallel word |
| memWrEn | output | 1 | Payload write strobe |
| memAddr | output | ADDR_W | Payload write address |
| memWrData | output | 16 | Payload write data |
| cfgDone | output | 1 | The whole image loaded and checked correctly |
| cfgErrN | output | 1 | Active-low sticky error flag |
| passData | output | 1 | Serial pass-through once loading is done |

## Verification
A parallel word is accepted at the first rising edge after `parWrEn` is driven. Its memory write and any flag change become visible after that same edge, and the bench samples them on the following falling edge. A serial word completes one clock after its sixteenth sampled edge, and its effect on the flags follows one clock after that. The bench therefore leaves three idle clocks after every serial word before it reads the counts or the flags. Pass-through bits are registered on the sampling clock, and the bench reads them two falling edges after it drives the active serial-clock level, which is safely later.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [WORD_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    LD_ID,
    LD_PAYLOAD,
    LD_CHECK,
    LD_DONE,
    LD_FAIL
  } ldState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;      // reseed CRC, clear counters and address
    logic takePayload;  // store word, fold into CRC, advance address
    logic nextBlock;    // reseed CRC, advance block counter
  } ldStrobe_t;

  // fold one word into a CRC, most significant bit first
  function automatic logic [WORD_W-1:0] crcFold(input logic [WORD_W-1:0] crcIn,
                                                input logic [WORD_W-1:0] word);
    logic [WORD_W-1:0] acc;
    acc = crcIn;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (acc[WORD_W-1] ^ word[i]) acc = {acc[WORD_W-2:0], 1'b0} ^ CRC_POLY;
      else acc = {acc[WORD_W-2:0], 1'b0};
    end
    return acc;
  endfunction

endpackage

// File: rtl/cfgld_serial_rx.sv
module cfgld_serial_rx
  import cfgld_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              edgeSel,
  input  logic              serClk,
  input  logic              frameSync,
  input  logic              serDataIn,
  input  logic              passEn,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData,
  output logic              passData
);

  localparam int CNT_W = $clog2(WORD_W);

  logic             serClkQ;
  logic             sampleNow;
  logic             busy;
  logic [CNT_W-1:0] bitCnt;
  logic [WORD_W-2:0] shiftQ;

  always_comb begin
    if (edgeSel) sampleNow = enable && serClkQ && !serClk;
    else         sampleNow = enable && !serClkQ && serClk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serClkQ   <= 1'b0;
      busy      <= 1'b0;
      bitCnt    <= '0;
      shiftQ    <= '0;
      wordValid <= 1'b0;
      wordData  <= '0;
      passData  <= 1'b0;
    end else begin
      serClkQ   <= serClk;
      wordValid <= 1'b0;
      if (sampleNow) begin
        if (frameSync) begin
          shiftQ <= (WORD_W-1)'(serDataIn);
          bitCnt <= CNT_W'(1);
          busy   <= 1'b1;
        end else if (busy) begin
          if (bitCnt == CNT_W'(WORD_W - 1)) begin
            wordData  <= {shiftQ, serDataIn};
            wordValid <= 1'b1;
            busy      <= 1'b0;
            bitCnt    <= '0;
          end else begin
            shiftQ <= {shiftQ[WORD_W-3:0], serDataIn};
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
        passData <= passEn ? serDataIn : 1'b0;
      end else if (!passEn) begin
        passData <= 1'b0;
      end
    end
  end

  // R11: pass-through output quiet unless enabled on the previous clock
  p_pass_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(passEn) |-> !passData);

  // R7: a completed word never coincides with an open frame
  p_word_closes_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> !busy || $past(sampleNow && frameSync));

endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgResetPulse,
  input  logic      standby,
  input  logic      wordValid,
  input  logic      idMatch,
  input  logic      crcMatch,
  input  logic      lastWord,
  input  logic      lastBlock,
  output ldStrobe_t strobe,
  output logic      cfgDone,
  output logic      cfgErrN
);

  ldState_t stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    if (cfgResetPulse) begin
      stateNext      = LD_ID;
      strobe.restart = 1'b1;
    end else if (standby) begin
      if (stateQ == LD_PAYLOAD || stateQ == LD_CHECK) stateNext = LD_ID;
    end else if (wordValid) begin
      unique case (stateQ)
        LD_ID: begin
          if (idMatch) begin
            stateNext      = LD_PAYLOAD;
            strobe.restart = 1'b1;
          end else begin
            stateNext = LD_FAIL;
          end
        end
        LD_PAYLOAD: begin
          strobe.takePayload = 1'b1;
          if (lastWord) stateNext = LD_CHECK;
        end
        LD_CHECK: begin
          if (!crcMatch)      stateNext = LD_FAIL;
          else if (lastBlock) stateNext = LD_DONE;
          else begin
            stateNext        = LD_PAYLOAD;
            strobe.nextBlock = 1'b1;
          end
        end
        default: stateNext = stateQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= LD_ID;
    else       stateQ <= stateNext;
  end

  assign cfgDone = (stateQ == LD_DONE);
  assign cfgErrN = (stateQ != LD_FAIL);

  // R6: error flag sticky until the reset-config pulse
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgErrN && !cfgResetPulse) |=> !cfgErrN);

  // R5: done flag sticky until the reset-config pulse (standby included)
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDone && !cfgResetPulse) |=> cfgDone);

  // R5: done and error never together
  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgDone && !cfgErrN));

  // R10: no payload taken during standby
  p_standby_no_take_r10: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> !strobe.takePayload);

endmodule

// File: rtl/cfgld_dp.sv
module cfgld_dp
  import cfgld_pkg::*;
#(
  parameter int              BLOCK_WORDS = 42,
  parameter int              NUM_BLOCKS  = 12,
  parameter logic [WORD_W-1:0] ID_WORD   = 16'h7725,
  localparam int PAY_WORDS = BLOCK_WORDS * NUM_BLOCKS,
  localparam int ADDR_W    = $clog2(PAY_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldStrobe_t         strobe,
  input  logic [WORD_W-1:0] wordData,
  output logic              idMatch,
  output logic              crcMatch,
  output logic              lastWord,
  output logic              lastBlock,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWrData
);

  localparam int WCNT_W = $clog2(BLOCK_WORDS + 1);
  localparam int BCNT_W = $clog2(NUM_BLOCKS + 1);

  logic [WORD_W-1:0] crcQ;
  logic [WCNT_W-1:0] wordCntQ;
  logic [BCNT_W-1:0] blockCntQ;
  logic [ADDR_W-1:0] addrQ;

  assign idMatch   = (wordData == ID_WORD);
  assign crcMatch  = (wordData == crcQ);
  assign lastWord  = (wordCntQ == WCNT_W'(BLOCK_WORDS - 1));
  assign lastBlock = (blockCntQ == BCNT_W'(NUM_BLOCKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcQ      <= CRC_SEED;
      wordCntQ  <= '0;
      blockCntQ <= '0;
      addrQ     <= '0;
      memWrEn   <= 1'b0;
      memAddr   <= '0;
      memWrData <= '0;
    end else begin
      memWrEn <= strobe.takePayload;
      if (strobe.restart) begin
        crcQ      <= CRC_SEED;
        wordCntQ  <= '0;
        blockCntQ <= '0;
        addrQ     <= '0;
      end else begin
        if (strobe.takePayload) begin
          crcQ      <= crcFold(crcQ, wordData);
          memAddr   <= addrQ;
          memWrData <= wordData;
          addrQ     <= addrQ + ADDR_W'(1);
          wordCntQ  <= lastWord ? '0 : wordCntQ + WCNT_W'(1);
        end
        if (strobe.nextBlock) begin
          crcQ      <= CRC_SEED;
          blockCntQ <= blockCntQ + BCNT_W'(1);
        end
      end
    end
  end

  // R3: every write lands inside the payload area
  p_addr_in_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (int'(memAddr) < PAY_WORDS));

  // R3: back-to-back writes use consecutive addresses
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfgld_pkg::*;
#(
  parameter int          BLOCK_WORDS = 42,
  parameter int          NUM_BLOCKS  = 12,
  parameter logic [15:0] ID_WORD     = 16'h7725,
  localparam int PAY_WORDS = BLOCK_WORDS * NUM_BLOCKS,
  localparam int ADDR_W    = $clog2(PAY_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgResetPulse,
  input  logic              standby,
  input  logic              serialMode,
  input  logic              edgeSel,
  input  logic              serClk,
  input  logic              frameSync,
  input  logic              serDataIn,
  input  logic              parWrEn,
  input  logic [15:0]       parData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWrData,
  output logic              cfgDone,
  output logic              cfgErrN,
  output logic              passData
);

  ldStrobe_t         strobe;
  logic              serValid;
  logic [WORD_W-1:0] serWord;
  logic              wordValid;
  logic [WORD_W-1:0] wordData;
  logic              idMatch, crcMatch, lastWord, lastBlock;

  cfgld_serial_rx u_rx (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (serialMode),
    .edgeSel   (edgeSel),
    .serClk    (serClk),
    .frameSync (frameSync),
    .serDataIn (serDataIn),
    .passEn    (cfgDone && serialMode),
    .wordValid (serValid),
    .wordData  (serWord),
    .passData  (passData)
  );

  assign wordValid = serialMode ? serValid : parWrEn;
  assign wordData  = serialMode ? serWord  : parData;

  cfgld_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cfgResetPulse (cfgResetPulse),
    .standby       (standby),
    .wordValid     (wordValid),
    .idMatch       (idMatch),
    .crcMatch      (crcMatch),
    .lastWord      (lastWord),
    .lastBlock     (lastBlock),
    .strobe        (strobe),
    .cfgDone       (cfgDone),
    .cfgErrN       (cfgErrN)
  );

  cfgld_dp #(
    .BLOCK_WORDS (BLOCK_WORDS),
    .NUM_BLOCKS  (NUM_BLOCKS),
    .ID_WORD     (ID_WORD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wordData  (wordData),
    .idMatch   (idMatch),
    .crcMatch  (crcMatch),
    .lastWord  (lastWord),
    .lastBlock (lastBlock),
    .memWrEn   (memWrEn),
    .memAddr   (memAddr),
    .memWrData (memWrData)
  );

endmodule

// File: tb/sim_cfg_image_loader.sv
module sim_cfg_image_loader;

  localparam int BW   = 4;
  localparam int NB   = 3;
  localparam int PAY  = BW * NB;
  localparam int IMGW = 1 + NB * (BW + 1);
  localparam int AW   = $clog2(PAY);

  logic clk = 0;
  logic rstN = 0;
  logic cfgResetPulse = 0, standby = 0, serialMode = 0, edgeSel = 0;
  logic serClk = 0, frameSync = 0, serDataIn = 0, parWrEn = 0;
  logic [15:0] parData = 0;
  logic memWrEn;
  logic [AW-1:0] memAddr;
  logic [15:0] memWrData;
  logic cfgDone, cfgErrN, passData;

  always #10 clk = ~clk;

  cfg_image_loader #(.BLOCK_WORDS(BW), .NUM_BLOCKS(NB), .ID_WORD(16'h7725)) u0 (
    .clk(clk), .rstN(rstN), .cfgResetPulse(cfgResetPulse), .standby(standby),
    .serialMode(serialMode), .edgeSel(edgeSel), .serClk(serClk), .frameSync(frameSync),
    .serDataIn(serDataIn), .parWrEn(parWrEn), .parData(parData), .memWrEn(memWrEn),
    .memAddr(memAddr), .memWrData(memWrData), .cfgDone(cfgDone), .cfgErrN(cfgErrN),
    .passData(passData)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // write monitor
  logic [15:0] memImg [PAY];
  int wrTotal = 0, orderBad = 0, lastAddr = -1;
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      if (int'(memAddr) < PAY) memImg[memAddr] = memWrData;
      else orderBad++;
      if (!(int'(memAddr) == 0 || int'(memAddr) == lastAddr + 1)) orderBad++;
      lastAddr = int'(memAddr);
      wrTotal++;
    end
  end

  logic [15:0] img [IMGW];
  logic [15:0] expPay [PAY];

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    r = c;
    for (int k = 15; k >= 0; k--) begin
      logic fb;
      fb = r[15] ^ d[k];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic buildImage(input int seed, input int badBlk);
    int p;
    p = 1;
    img[0] = 16'h7725;
    for (int b = 0; b < NB; b++) begin
      logic [15:0] c;
      c = 16'hFFFF;
      for (int w = 0; w < BW; w++) begin
        logic [15:0] v;
        v = 16'(seed * 16'h3A7 + (b * BW + w) * 16'h1F1) ^ 16'((b * BW + w) << 5);
        expPay[b * BW + w] = v;
        img[p] = v;
        c = refCrc(c, v);
        p++;
      end
      img[p] = (b == badBlk) ? (c ^ 16'h0001) : c;
      p++;
    end
  endtask

  task automatic sendBit(input logic b, input logic fs);
    @(negedge clk);
    serClk = edgeSel; serDataIn = b; frameSync = fs;
    repeat (2) @(negedge clk);
    serClk = ~edgeSel;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendSerial(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) sendBit(w[i], i == 15);
    frameSync = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendPar(input logic [15:0] w);
    @(negedge clk);
    parData = w; parWrEn = 1;
    @(negedge clk);
    parWrEn = 0;
    @(negedge clk);
  endtask

  task automatic sendWord(input logic [15:0] w);
    if (serialMode) sendSerial(w);
    else sendPar(w);
  endtask

  task automatic sendImage(input int nWords);
    for (int i = 0; i < nWords; i++) sendWord(img[i]);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseReset();
    @(negedge clk); cfgResetPulse = 1;
    @(negedge clk); cfgResetPulse = 0;
    @(negedge clk);
  endtask

  function automatic int payMismatch(input int n);
    int m;
    m = 0;
    for (int i = 0; i < n; i++) if (memImg[i] !== expPay[i]) m++;
    return m;
  endfunction

  task automatic goodLoadChecks(input string req, input int wrBefore, input int extra);
    chk(cfgDone == 1, req, cfgDone, 1);
    chk(cfgErrN == 1, req, cfgErrN, 1);
    chk(wrTotal - wrBefore == PAY + extra, req, wrTotal - wrBefore, PAY + extra);
    chk(payMismatch(PAY) == 0, req, payMismatch(PAY), 0);
    chk(orderBad == 0, "R3 address order", orderBad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int wb;
    logic [15:0] badIds [4];
    logic [15:0] pw;
    badIds[0] = 16'h0000; badIds[1] = 16'h7724; badIds[2] = 16'hF725; badIds[3] = 16'h7726;

    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(cfgDone == 0, "R1 done", cfgDone, 0);
    chk(cfgErrN == 1, "R1 errN", cfgErrN, 1);
    chk(memWrEn == 0, "R1 memWrEn", memWrEn, 0);
    chk(passData == 0, "R1 passData", passData, 0);

    // R3 R4 R5 R9: parallel good images, seed sweep
    for (int s = 1; s <= 3; s++) begin
      pulseReset();
      buildImage(s, -1);
      wb = wrTotal;
      sendImage(IMGW);
      goodLoadChecks("R3 R4 R9 parallel load", wb, 0);
    end
    // R5: words after done write nothing
    wb = wrTotal;
    sendPar(16'h7725); sendPar(16'h1234);
    chk(wrTotal == wb, "R5 ignore after done", wrTotal - wb, 0);
    chk(cfgDone == 1, "R5 done held", cfgDone, 1);

    // R2 R6: bad identifier sweep
    foreach (badIds[k]) begin
      pulseReset();
      chk(cfgErrN == 1 && cfgDone == 0, "R6 pulse clears flags", {cfgErrN, cfgDone}, 2);
      wb = wrTotal;
      sendPar(badIds[k]);
      chk(cfgErrN == 0, "R2 bad id flags error", cfgErrN, 0);
      buildImage(5, -1);
      sendImage(IMGW);
      chk(wrTotal == wb, "R2 R6 no writes after bad id", wrTotal - wb, 0);
      chk(cfgErrN == 0 && cfgDone == 0, "R6 error sticky", {cfgErrN, cfgDone}, 0);
    end
    pulseReset();
    chk(cfgErrN == 1, "R6 pulse releases error", cfgErrN, 1);

    // R4: check-word error in each block
    for (int b = 0; b < NB; b++) begin
      pulseReset();
      buildImage(11 + b, b);
      wb = wrTotal;
      sendImage(IMGW);
      chk(cfgErrN == 0, "R4 bad crc flags error", cfgErrN, 0);
      chk(cfgDone == 0, "R4 no done on bad crc", cfgDone, 0);
      chk(wrTotal - wb == (b + 1) * BW, "R4 writes stop after bad block", wrTotal - wb, (b + 1) * BW);
    end

    // R10: standby during a partial load restarts at identifier
    pulseReset();
    buildImage(21, -1);
    wb = wrTotal;
    sendImage(3);
    @(negedge clk); standby = 1;
    sendPar(16'h7725);
    sendPar(16'h5555);
    chk(wrTotal - wb == 2, "R10 no writes in standby", wrTotal - wb, 2);
    @(negedge clk); standby = 0;
    sendImage(IMGW);
    goodLoadChecks("R10 restart after standby", wb, 2);
    @(negedge clk); standby = 1;
    repeat (4) @(negedge clk);
    standby = 0;
    @(negedge clk);
    chk(cfgDone == 1, "R10 done kept over standby", cfgDone, 1);

    // R9: in parallel mode the serial pins do nothing
    pulseReset();
    sendSerial(16'h0000);
    chk(cfgErrN == 1, "R9 serial ignored in parallel mode", cfgErrN, 1);

    // R7 R8 R9: serial rising edge
    serialMode = 1; edgeSel = 0;
    pulseReset();
    wb = wrTotal;
    sendPar(16'h0000);
    chk(cfgErrN == 1 && wrTotal == wb, "R9 parallel ignored in serial mode", cfgErrN, 1);
    for (int j = 0; j < 5; j++) sendBit(1'(j), 1'b0);   // R7 unframed bits ignored
    buildImage(31, -1);
    wb = wrTotal;
    sendImage(IMGW);
    goodLoadChecks("R7 R8 serial rising", wb, 0);

    // R11: pass-through after done
    pw = 16'hB2C5;
    begin
      int mis;
      mis = 0;
      for (int i = 15; i >= 0; i--) begin
        sendBit(pw[i], i == 15);
        if (passData !== pw[i]) mis++;
      end
      frameSync = 0;
      chk(mis == 0, "R11 pass-through bits", mis, 0);
    end
    chk(cfgDone == 1, "R11 done kept while forwarding", cfgDone, 1);

    // R8: serial falling edge, good then bad crc
    @(negedge clk); edgeSel = 1; serClk = 1;
    repeat (2) @(negedge clk);
    pulseReset();
    chk(passData == 0, "R11 quiet when not done", passData, 0);
    buildImage(41, -1);
    wb = wrTotal;
    sendImage(IMGW);
    goodLoadChecks("R8 serial falling", wb, 0);
    pulseReset();
    buildImage(43, 1);
    wb = wrTotal;
    sendImage(IMGW);
    chk(cfgErrN == 0, "R4 R8 serial bad crc", cfgErrN, 0);
    chk(wrTotal - wb == 2 * BW, "R4 R8 serial writes stop", wrTotal - wb, 2 * BW);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule